// File: doc/BRIEF.md
# Asynchronous Up/Down Event Tracker

This block keeps a net event count when "increment" and "decrement" events arrive as rising edges on two clocks that have no fixed relation to each other or to the clock that reads the result. It does not use one counter with two clock inputs. Each event clock instead advances its own private counter, and both counters only ever count upward. Each counter is held in Gray code, so a snapshot taken at any moment sees either the old value or the new one, never a blend of bits from both.

A third clock, the sampling clock, passes each Gray value through a chain of synchronizer flops and converts it to binary. It then subtracts the decrement total from the increment total modulo 2^CNT_W. The output is this difference read as a signed two's-complement number. Either counter may wrap any number of times. The result stays exact as long as the true net count fits in the signed range of CNT_W bits.

Top module: `updown_gray_tracker`

## Requirements
- R1: While rst_i is high, rising edges on either event clock are ignored. Once reset has been released and no event has occurred since, diff_o reads 0.
- R2: Each rising edge of up_clk_i raises the net count by exactly one.
- R3: Each rising edge of dn_clk_i lowers the net count by exactly one.
- R4: Each counter register changes in exactly one bit per event (Gray code). As a result, events that arrive at the same time on the two unrelated clocks are each counted exactly once.
- R5: diff_o equals (increment events minus decrement events) modulo 2^CNT_W, presented as a signed two's-complement value. Negative net counts therefore read below zero.
- R6: When either counter passes its all-ones value and wraps, diff_o stays correct, provided the true net count stays within the signed CNT_W-bit range.
- R7: With the default output register, diff_o reflects every event no later than SYNC_STAGES+1 sampling-clock rising edges after that event. It holds its value on every cycle in which neither synchronized count changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| up_clk_i | input | 1 | Increment event clock; each rising edge is one event |
| dn_clk_i | input | 1 | Decrement event clock; each rising edge is one event |
| smp_clk_i | input | 1 | Sampling clock that owns the output |
| rst_i | input | 1 | Active-high reset, sampled synchronously by each of the three clocks |
| diff_o | output | CNT_W | Signed net count (increments minus decrements), sampling-clock domain |

## Verification
Three properties are checked on every clock edge of their own domain. In each event domain, every step of a counter register changes exactly one bit, and its binary value rises by exactly one. In the sampling domain, the output holds whenever the synchronized counts hold. Only the bench scenarios can show that the arithmetic result is right: the modulo difference, the correct reading of negative values, the wrap of each counter after dozens of events, and the exact count when both event clocks run at once at unrelated rates. The bench compares each of these against totals it keeps itself. It also shows the settling bound by reading the output on the last allowed sampling edge.

// File: rtl/dgt_pkg.sv
package dgt_pkg;
   // Smallest legal configuration values, checked at elaboration.
   localparam int unsigned MIN_CNT_W      = 2;
   localparam int unsigned MIN_SYNC_STAGE = 2;
endpackage

// File: rtl/dgt_gray2bin.sv
module dgt_gray2bin #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] gray_i,
   output logic [W-1:0] bin_o
);
   // Binary bit i is the XOR of all Gray bits from the MSB down to i.
   assign bin_o[W-1] = gray_i[W-1];
   for (genvar i = W - 2; i >= 0; i--) begin : g_bit
      assign bin_o[i] = bin_o[i+1] ^ gray_i[i];
   end
endmodule

// File: rtl/dgt_gray_ctr.sv
module dgt_gray_ctr #(
   parameter int unsigned W = 8
) (
   input  logic         clk_i,
   input  logic         rst_i,
   output logic [W-1:0] gray_o
);
   logic [W-1:0] bin_q;
   logic [W-1:0] bin_nx;
   logic [W-1:0] gray_q;

   assign bin_nx = bin_q + W'(1);

   // The Gray register is loaded directly, so its output carries no glitch.
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         bin_q  <= '0;
         gray_q <= '0;
      end else begin
         bin_q  <= bin_nx;
         gray_q <= bin_nx ^ (bin_nx >> 1);
      end
   end

   assign gray_o = gray_q;

   // Independent decode of the Gray register, used only by the checks below.
   logic [W-1:0] chk_bin;
   dgt_gray2bin #(.W(W)) chk_dec_i (.gray_i(gray_q), .bin_o(chk_bin));

   a_r4_one_bit: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(rst_i) |-> $countones(gray_q ^ $past(gray_q)) == 1)
      else $error("R4: Gray register moved by other than one bit");

   // R2 for the increment counter, R3 for the decrement counter.
   a_r2_count_step: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(rst_i) |-> chk_bin == $past(chk_bin) + W'(1))
      else $error("R2/R3: counter did not advance by one");
endmodule

// File: rtl/dgt_sync.sv
module dgt_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stg_q [STAGES];

   for (genvar s = 0; s < int'(STAGES); s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i) begin
            if (rst_i) stg_q[s] <= '0;
            else       stg_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i) begin
            if (rst_i) stg_q[s] <= '0;
            else       stg_q[s] <= stg_q[s-1];
         end
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dgt_diff.sv
module dgt_diff #(
   parameter int unsigned W       = 8,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic                clk_i,
   input  logic                rst_i,
   input  logic [W-1:0]        up_gray_i,
   input  logic [W-1:0]        dn_gray_i,
   output logic signed [W-1:0] diff_o
);
   logic [W-1:0] up_bin;
   logic [W-1:0] dn_bin;
   logic [W-1:0] raw_diff;

   dgt_gray2bin #(.W(W)) up_dec_i (.gray_i(up_gray_i), .bin_o(up_bin));
   dgt_gray2bin #(.W(W)) dn_dec_i (.gray_i(dn_gray_i), .bin_o(dn_bin));

   // The subtraction wraps modulo 2^W, so counter wrap cancels out.
   assign raw_diff = up_bin - dn_bin;

   if (OUT_REG) begin : g_reg
      logic signed [W-1:0] diff_q;
      always_ff @(posedge clk_i) begin
         if (rst_i) diff_q <= '0;
         else       diff_q <= signed'(raw_diff);
      end
      assign diff_o = diff_q;

      a_r7_hold: assert property (@(posedge clk_i) disable iff (rst_i)
         ($stable(up_gray_i) && $stable(dn_gray_i)) |=> $stable(diff_q))
         else $error("R7: output moved while synchronized counts held");
   end else begin : g_comb
      assign diff_o = signed'(raw_diff);
   end
endmodule

// File: rtl/updown_gray_tracker.sv
module updown_gray_tracker
   import dgt_pkg::*;
#(
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          OUT_REG     = 1'b1
) (
   input  logic                    up_clk_i,
   input  logic                    dn_clk_i,
   input  logic                    smp_clk_i,
   input  logic                    rst_i,
   output logic signed [CNT_W-1:0] diff_o
);
   if (CNT_W < MIN_CNT_W) begin : g_bad_width
      initial $error("CNT_W below minimum");
   end
   if (SYNC_STAGES < MIN_SYNC_STAGE) begin : g_bad_sync
      initial $error("SYNC_STAGES below minimum");
   end

   logic [CNT_W-1:0] up_gray;
   logic [CNT_W-1:0] dn_gray;
   logic [CNT_W-1:0] up_gray_s;
   logic [CNT_W-1:0] dn_gray_s;

   dgt_gray_ctr #(.W(CNT_W)) up_ctr_i (
      .clk_i(up_clk_i), .rst_i(rst_i), .gray_o(up_gray));
   dgt_gray_ctr #(.W(CNT_W)) dn_ctr_i (
      .clk_i(dn_clk_i), .rst_i(rst_i), .gray_o(dn_gray));

   dgt_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) up_sync_i (
      .clk_i(smp_clk_i), .rst_i(rst_i), .d_i(up_gray), .q_o(up_gray_s));
   dgt_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) dn_sync_i (
      .clk_i(smp_clk_i), .rst_i(rst_i), .d_i(dn_gray), .q_o(dn_gray_s));

   dgt_diff #(.W(CNT_W), .OUT_REG(OUT_REG)) diff_i (
      .clk_i(smp_clk_i), .rst_i(rst_i),
      .up_gray_i(up_gray_s), .dn_gray_i(dn_gray_s), .diff_o(diff_o));

   a_r1_reset_zero: assert property (@(posedge smp_clk_i)
      rst_i |=> diff_o == '0)
      else $error("R1: output not zero after reset");
endmodule

// File: tb/updown_gray_tracker_tb_top.sv
module updown_gray_tracker_tb_top;
   localparam int unsigned CW = 4;

   logic up_clk = 1'b0;
   logic dn_clk = 1'b0;
   logic smp_clk = 1'b0;
   logic rst = 1'b1;
   logic signed [CW-1:0] diff;

   int compared = 0;
   int mismatched = 0;
   int tot_up = 0;
   int tot_dn = 0;

   always #10 smp_clk = ~smp_clk;  // 50 MHz sampling clock

   updown_gray_tracker #(.CNT_W(CW), .SYNC_STAGES(2), .OUT_REG(1'b1)) dut_i (
      .up_clk_i(up_clk), .dn_clk_i(dn_clk), .smp_clk_i(smp_clk),
      .rst_i(rst), .diff_o(diff));

   task automatic chk(input string rq, input logic [CW-1:0] act,
                      input logic [CW-1:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: got %0d expected %0d", rq, $signed(act), $signed(exp));
      end
   endtask

   function automatic logic [CW-1:0] model();
      return CW'(tot_up - tot_dn);
   endfunction

   task automatic pulse_up(input int n);
      for (int i = 0; i < n; i++) begin
         #7 up_clk = 1'b1;
         #7 up_clk = 1'b0;
         if (!rst) tot_up++;
      end
   endtask

   task automatic pulse_dn(input int n);
      for (int i = 0; i < n; i++) begin
         #9 dn_clk = 1'b1;
         #8 dn_clk = 1'b0;
         if (!rst) tot_dn++;
      end
   endtask

   // Three sampling edges (two sync flops plus output register), then sample mid-cycle.
   task automatic settle();
      repeat (3) @(posedge smp_clk);
      #3;
   endtask

   initial begin
      // R1: events during reset are ignored
      pulse_up(3);
      pulse_dn(2);
      repeat (4) @(posedge smp_clk);
      #3 rst = 1'b0;
      settle();
      chk("R1 reset value", diff, '0);

      // R2: single increments
      for (int i = 1; i <= 7; i++) begin
         pulse_up(1);
         settle();
         chk("R2 increment", diff, model());
      end

      // R3 and R5: single decrements down into the negative range
      for (int i = 1; i <= 15; i++) begin
         pulse_dn(1);
         settle();
         chk("R3 decrement", diff, model());
      end
      chk("R5 most negative", diff, 4'b1000);

      // R4 / R5: concurrent bursts on both unrelated clocks
      for (int k = 0; k < 24; k++) begin
         fork
            pulse_up((k * 5) % 8);
            pulse_dn((k * 3) % 7);
         join
         settle();
         chk("R4 concurrent events", diff, model());
      end

      // R6: long bursts that wrap each counter several times
      tot_up = tot_up - tot_dn;
      tot_dn = 0;
      pulse_up(37);
      pulse_dn(37);
      settle();
      chk("R6 wrap balanced", diff, model());
      pulse_dn(40);
      pulse_up(43);
      settle();
      chk("R6 wrap net", diff, model());

      // R7: settled value holds with no events
      repeat (10) @(posedge smp_clk);
      #3 chk("R7 hold", diff, model());

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      #3_000_000;
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule